// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits next to a free-running 16-bit counter and records the counter's value when a capture event happens. The event is an edge on an external trigger pin or, when selected, on an analog comparator output. The trigger passes through a two-stage synchronizer. A control bit selects whether a rising or a falling edge counts. Each capture loads the 16-bit capture register and raises the capture flag. Software can also take the captured value as the counter's TOP limit instead of the fixed all-ones wrap.

A processor with an 8-bit bus reaches two 16-bit registers: the capture value and the compare-A value. It reaches them one byte at a time through a single shared high-byte holding register. Reading a low byte parks the matching high byte in the holding register. Writing a high byte only fills the holding register, and the next low-byte write updates all 16 bits in one cycle.

The block also keeps four event flags: capture, compare A, compare B and overflow. Each flag has an enable bit in a mask register. An interrupt line for a source is raised only when its flag, its mask bit and the global enable are all set.

Top module: `timer_capture_unit`

## Requirements
- R1: After synchronous reset the mask, flags, control, capture and compare registers read 0, `irq_o` is 0, `bus_rdata_o` is 0, `cmpa_o` is 0 and `top_o` is all ones.
- R2: A selected trigger edge seen on the input before clock edge k loads the capture register, at clock edge k+2, with the `cnt_i` value present at that edge. The same edge sets the capture flag.
- R3: Control bit 1 selects the active edge: 1 means rising and 0 means falling. An edge of the other polarity neither loads the register nor sets the flag.
- R4: Control bit 0 selects the source: 0 is `trig_pin_i` and 1 is `trig_cmp_i`. Activity on the unselected input is ignored.
- R5: The bus addresses are 0 capture low, 1 capture high, 2 compare-A low, 3 compare-A high, 4 mask, 5 flags and 6 control. Read data appears on `bus_rdata_o` one cycle after the read strobe. A low-byte read copies that register's high byte into the shared holding register. A high-byte read returns the holding register, even if a capture has changed the register since the low-byte read.
- R6: A high-byte write changes only the shared holding register. A low-byte write loads {holding, data} into its 16-bit register in one cycle. One holding register serves both 16-bit registers, and `cmpa_o` shows the compare-A register.
- R7: When control bit 2 is 1, `top_o` shows the capture register and capture events neither load it nor set the flag. When the bit is 0, `top_o` is all ones. `top_o` follows the control and register state one clock later.
- R8: The flag register holds capture at bit 5, compare A at bit 4, compare B at bit 3 and overflow at bit 2. Pulses on `match_a_i`, `match_b_i` and `ovf_i` set their flags. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and the other bits read 0.
- R9: If a flag's set event and its clear write fall in the same cycle, the flag ends up set.
- R10: A pulse on `cap_ack_i` clears the capture flag.
- R11: The mask register uses the same bit positions as the flags, and its other bits read 0. `irq_o` bits [3:0] (capture, compare A, compare B, overflow) equal flag AND mask AND `global_ie_i`, registered one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Current counter value |
| trig_pin_i | input | 1 | External trigger pin (asynchronous) |
| trig_cmp_i | input | 1 | Comparator output trigger (asynchronous) |
| match_a_i | input | 1 | Compare-A match pulse |
| match_b_i | input | 1 | Compare-B match pulse |
| ovf_i | input | 1 | Counter overflow pulse |
| global_ie_i | input | 1 | Global interrupt enable |
| cap_ack_i | input | 1 | Capture interrupt acknowledge |
| bus_addr_i | input | 3 | Byte register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 4 | Interrupt requests: capture, compare A, compare B, overflow |
| top_o | output | 16 | Counter limit in use |
| cmpa_o | output | 16 | Compare-A register value |

## Verification
The assertions assume that read and write strobes are never active in the same cycle. They also assume that the holding-register checks hold only when no other 16-bit access comes between a low-byte and a high-byte access. The bench issues one bus operation per cycle and keeps each byte pair together, except where it deliberately inserts a capture between the two halves. Trigger inputs change only on falling clock edges and are held for at least three cycles, so every edge crosses the synchronizer cleanly. The bench changes the source and edge selects only while the selected input is steady, so no spurious edge is created.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTL_W  = 3;
  localparam int unsigned NSRC   = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CAP_LO = 3'd0,
    A_CAP_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_MASK   = 3'd4,
    A_FLAG   = 3'd5,
    A_CTRL   = 3'd6
  } reg_addr_e;

  localparam int unsigned CTL_SRC  = 0;
  localparam int unsigned CTL_RISE = 1;
  localparam int unsigned CTL_TOP  = 2;

  // lowest byte position of the four-bit flag / mask field
  localparam int unsigned FLD_LO   = 2;
  // index inside the four-bit field
  localparam int unsigned S_OVF  = 0;
  localparam int unsigned S_CMPB = 1;
  localparam int unsigned S_CMPA = 2;
  localparam int unsigned S_CAP  = 3;
endpackage

// File: rtl/tcu_trig_sync.sv
module tcu_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic cmp_i,
  input  logic src_sel_i,
  input  logic rise_i,
  output logic evt_o
);
  // [STAGES-1] is the synchronized level, [STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic            src;
  logic            cur;
  logic            prv;

  assign src = src_sel_i ? cmp_i : pin_i;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], src};
  end

  assign cur   = sh_q[STAGES-1];
  assign prv   = sh_q[STAGES];
  assign evt_o = rise_i ? (cur & ~prv) : (~cur & prv);

  // R2: one detected edge gives exactly one event cycle
  assert_evt_single_R2: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);
endmodule

// File: rtl/tcu_wide_regs.sv
module tcu_wide_regs
  import tcu_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cap_evt_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cap_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  logic [HI_W-1:0]  temp_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cmp_q;

  logic wr_hi, rd_cap_lo, rd_cmp_lo, wr_cap_lo, wr_cmp_lo;
  assign wr_hi     = wr_i && (addr_i == A_CAP_HI || addr_i == A_CMP_HI);
  assign wr_cap_lo = wr_i && (addr_i == A_CAP_LO);
  assign wr_cmp_lo = wr_i && (addr_i == A_CMP_LO);
  assign rd_cap_lo = rd_i && (addr_i == A_CAP_LO);
  assign rd_cmp_lo = rd_i && (addr_i == A_CMP_LO);

  // shared high-byte holding register
  always_ff @(posedge clk) begin
    if (rst)            temp_q <= '0;
    else if (wr_hi)     temp_q <= wdata_i[HI_W-1:0];
    else if (rd_cap_lo) temp_q <= cap_q[CNT_W-1:BUS_W];
    else if (rd_cmp_lo) temp_q <= cmp_q[CNT_W-1:BUS_W];
  end

  // capture event has priority over a software commit
  always_ff @(posedge clk) begin
    if (rst)            cap_q <= '0;
    else if (cap_evt_i) cap_q <= cnt_i;
    else if (wr_cap_lo) cap_q <= {temp_q, wdata_i};
  end

  always_ff @(posedge clk) begin
    if (rst)            cmp_q <= '0;
    else if (wr_cmp_lo) cmp_q <= {temp_q, wdata_i};
  end

  always_comb begin
    case (addr_i)
      A_CAP_LO: rdata_o = cap_q[BUS_W-1:0];
      A_CMP_LO: rdata_o = cmp_q[BUS_W-1:0];
      A_CAP_HI,
      A_CMP_HI: rdata_o = BUS_W'(temp_q);
      default:  rdata_o = '0;
    endcase
  end

  assign cap_o = cap_q;
  assign cmp_o = cmp_q;

  assert_capture_load_R2: assert property (@(posedge clk) disable iff (rst)
    cap_evt_i |=> cap_q == $past(cnt_i));

  assert_low_commit_R6: assert property (@(posedge clk) disable iff (rst)
    wr_cmp_lo |=> cmp_q == {$past(temp_q), $past(wdata_i)});

  assert_temp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !wr_i && addr_i == A_CAP_HI) |=> $stable(temp_q));
endmodule

// File: rtl/tcu_irq_ctrl.sv
module tcu_irq_ctrl
  import tcu_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  set_i,
  input  logic             wr_mask_i,
  input  logic             wr_flag_i,
  input  logic [NSRC-1:0]  wfield_i,
  input  logic             ack_cap_i,
  input  logic             gie_i,
  output logic [BUS_W-1:0] mask_byte_o,
  output logic [BUS_W-1:0] flag_byte_o,
  output logic [NSRC-1:0]  irq_o
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] irq_q;
  logic [NSRC-1:0] clr;

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (wr_mask_i) mask_q <= wfield_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    if (i == S_CAP) begin : g_ack
      assign clr[i] = (wr_flag_i & wfield_i[i]) | ack_cap_i;
    end else begin : g_plain
      assign clr[i] = wr_flag_i & wfield_i[i];
    end
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr[i])   flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= flag_q & mask_q & {NSRC{gie_i}};
  end

  always_comb begin
    mask_byte_o = '0;
    flag_byte_o = '0;
    mask_byte_o[FLD_LO +: NSRC] = mask_q;
    flag_byte_o[FLD_LO +: NSRC] = flag_q;
  end

  assign irq_o = irq_q;

  assert_irq_gie_R11: assert property (@(posedge clk) disable iff (rst)
    (|irq_q) |-> $past(gie_i));

  assert_irq_mask_R11: assert property (@(posedge clk) disable iff (rst)
    (|irq_q) |-> ((irq_q & ~$past(mask_q)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/timer_capture_unit.sv
module timer_capture_unit
  import tcu_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              trig_pin_i,
  input  logic              trig_cmp_i,
  input  logic              match_a_i,
  input  logic              match_b_i,
  input  logic              ovf_i,
  input  logic              global_ie_i,
  input  logic              cap_ack_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic [NSRC-1:0]   irq_o,
  output logic [CNT_W-1:0]  top_o,
  output logic [CNT_W-1:0]  cmpa_o
);
  logic [CTL_W-1:0] ctrl_q;
  logic             evt_raw;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_val;
  logic [BUS_W-1:0] wide_rdata;
  logic [BUS_W-1:0] mask_byte;
  logic [BUS_W-1:0] flag_byte;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;
  logic [CNT_W-1:0] top_q;
  logic [NSRC-1:0]  set_vec;

  always_ff @(posedge clk) begin
    if (rst)                                   ctrl_q <= '0;
    else if (bus_wr_i && bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i[CTL_W-1:0];
  end

  tcu_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (trig_pin_i),
    .cmp_i    (trig_cmp_i),
    .src_sel_i(ctrl_q[CTL_SRC]),
    .rise_i   (ctrl_q[CTL_RISE]),
    .evt_o    (evt_raw)
  );

  // in limit mode the register belongs to software
  assign cap_evt = evt_raw & ~ctrl_q[CTL_TOP];

  tcu_wide_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_wide (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (cnt_i),
    .cap_evt_i(cap_evt),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .cap_o    (cap_val),
    .cmp_o    (cmpa_o),
    .rdata_o  (wide_rdata)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[S_CAP]  = cap_evt;
    set_vec[S_CMPA] = match_a_i;
    set_vec[S_CMPB] = match_b_i;
    set_vec[S_OVF]  = ovf_i;
  end

  tcu_irq_ctrl #(.BUS_W(BUS_W)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_vec),
    .wr_mask_i  (bus_wr_i && bus_addr_i == A_MASK),
    .wr_flag_i  (bus_wr_i && bus_addr_i == A_FLAG),
    .wfield_i   (bus_wdata_i[FLD_LO +: NSRC]),
    .ack_cap_i  (cap_ack_i),
    .gie_i      (global_ie_i),
    .mask_byte_o(mask_byte),
    .flag_byte_o(flag_byte),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (bus_addr_i)
      A_CAP_LO, A_CAP_HI, A_CMP_LO, A_CMP_HI: rd_mux = wide_rdata;
      A_MASK:  rd_mux = mask_byte;
      A_FLAG:  rd_mux = flag_byte;
      A_CTRL:  rd_mux = BUS_W'(ctrl_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst) top_q <= '1;
    else     top_q <= ctrl_q[CTL_TOP] ? cap_val : '1;
  end

  assign bus_rdata_o = rdata_q;
  assign top_o       = top_q;

  assert_top_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_TOP] && !bus_wr_i) |=> $stable(cap_val));
endmodule

// File: tb/tb_timer_capture_unit.sv
module tb_timer_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt = '0;
  logic        pin = 1'b0, cmp = 1'b0;
  logic        ma = 1'b0, mb = 1'b0, ovf = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  irq;
  logic [15:0] top, cmpa;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  timer_capture_unit dut (
    .clk(clk), .rst(rst), .cnt_i(cnt), .trig_pin_i(pin), .trig_cmp_i(cmp),
    .match_a_i(ma), .match_b_i(mb), .ovf_i(ovf), .global_ie_i(gie),
    .cap_ack_i(ack), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .top_o(top),
    .cmpa_o(cmpa)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor compares it
  task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    addr = a; rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    tick();
    rd = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      logic was;
      @(posedge clk);
      was = rd;
      #1;
      if (was) begin
        if (exp_q.size() == 0) begin
          check("monitor underflow", 32'd1, 32'd0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {24'd0, rdata}, {24'd0, e});
        end
      end
    end
  end

  // drive a level onto the chosen trigger, counter values a,b,c over three edges
  task automatic trig(input bit use_cmp, input logic lvl,
                      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    if (use_cmp) cmp = lvl; else pin = lvl;
    cnt = a; tick();
    cnt = b; tick();
    cnt = c; tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {28'd0, irq}, 32'd0);
    check("R1 top", {16'd0, top}, 32'h0000FFFF);
    check("R1 cmpa", {16'd0, cmpa}, 32'd0);
    check("R1 rdata", {24'd0, rdata}, 32'd0);
    bus_rd(3'd4, 8'h00, "R1 mask");
    bus_rd(3'd5, 8'h00, "R1 flag");
    bus_rd(3'd6, 8'h00, "R1 ctrl");
    bus_rd(3'd0, 8'h00, "R1 cap lo");

    // R2 rising edge on pin captures counter at edge k+2
    bus_wr(3'd6, 8'h02);
    trig(1'b0, 1'b1, 16'h1111, 16'h2222, 16'hA5C3);
    bus_rd(3'd0, 8'hC3, "R2 cap lo");
    bus_rd(3'd1, 8'hA5, "R2 cap hi");
    bus_rd(3'd5, 8'h20, "R2 flag set");

    // R8 write 1 clears
    bus_wr(3'd5, 8'h20);
    bus_rd(3'd5, 8'h00, "R8 flag cleared");
    // R3 falling edge ignored in rising mode
    trig(1'b0, 1'b0, 16'h0101, 16'h0202, 16'h0303);
    tick();
    bus_rd(3'd5, 8'h00, "R3 wrong edge no flag");
    bus_rd(3'd0, 8'hC3, "R3 wrong edge no load");
    // R5 capture between low and high read
    trig(1'b0, 1'b1, 16'h0000, 16'h0000, 16'h1234);
    bus_rd(3'd1, 8'hA5, "R5 high from holding");
    bus_rd(3'd0, 8'h34, "R5 new lo");
    bus_rd(3'd1, 8'h12, "R5 new hi");

    // R3 falling mode
    bus_wr(3'd6, 8'h00);
    trig(1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0F0E);
    bus_rd(3'd0, 8'h0E, "R3 falling lo");
    bus_rd(3'd1, 8'h0F, "R3 falling hi");

    // R4 comparator source, pin ignored
    bus_wr(3'd6, 8'h01);
    bus_wr(3'd5, 8'h20);
    trig(1'b0, 1'b1, 16'h0000, 16'h0000, 16'h7777);
    trig(1'b0, 1'b0, 16'h0000, 16'h0000, 16'h8888);
    tick();
    bus_rd(3'd5, 8'h00, "R4 pin ignored flag");
    bus_rd(3'd0, 8'h0E, "R4 pin ignored reg");
    bus_wr(3'd6, 8'h03);
    trig(1'b1, 1'b1, 16'h0000, 16'h0000, 16'hBEEF);
    bus_rd(3'd0, 8'hEF, "R4 cmp lo");
    bus_rd(3'd1, 8'hBE, "R4 cmp hi");
    bus_rd(3'd5, 8'h20, "R4 cmp flag");

    // R6 shared holding register
    bus_wr(3'd1, 8'h77);
    bus_wr(3'd2, 8'h11);
    check("R6 cmpa commit", {16'd0, cmpa}, 32'h7711);
    bus_wr(3'd3, 8'h99);
    check("R6 hi write only holding", {16'd0, cmpa}, 32'h7711);
    bus_wr(3'd2, 8'h22);
    check("R6 cmpa second commit", {16'd0, cmpa}, 32'h9922);
    bus_rd(3'd2, 8'h22, "R6 cmp lo read");
    bus_rd(3'd3, 8'h99, "R6 cmp hi read");
    bus_rd(3'd0, 8'hEF, "R6 cap untouched");

    // R7 capture register as TOP
    bus_wr(3'd1, 8'h40);
    bus_wr(3'd0, 8'h00);
    bus_wr(3'd6, 8'h07);
    bus_wr(3'd5, 8'h20);
    tick(); tick();
    check("R7 top from cap", {16'd0, top}, 32'h4000);
    trig(1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000);
    trig(1'b1, 1'b1, 16'h0000, 16'h0000, 16'h5555);
    tick();
    check("R7 top unchanged", {16'd0, top}, 32'h4000);
    bus_rd(3'd5, 8'h00, "R7 no flag");
    bus_rd(3'd0, 8'h00, "R7 reg lo kept");
    bus_rd(3'd1, 8'h40, "R7 reg hi kept");
    bus_wr(3'd6, 8'h03);
    tick(); tick();
    check("R7 top back to max", {16'd0, top}, 32'h0000FFFF);

    // R8 / R9 flags from match and overflow pulses
    ma = 1'b1; tick(); ma = 1'b0;
    bus_rd(3'd5, 8'h10, "R8 cmpa flag");
    bus_wr(3'd5, 8'h00);
    bus_rd(3'd5, 8'h10, "R8 write 0 no effect");
    ma = 1'b1; addr = 3'd5; wdata = 8'h10; wr = 1'b1;
    tick();
    ma = 1'b0; wr = 1'b0;
    bus_rd(3'd5, 8'h10, "R9 set wins");
    bus_wr(3'd5, 8'h10);
    ovf = 1'b1; tick(); ovf = 1'b0;
    bus_rd(3'd5, 8'h04, "R8 ovf flag");
    mb = 1'b1; tick(); mb = 1'b0;
    bus_rd(3'd5, 8'h0C, "R8 cmpb flag");
    bus_wr(3'd5, 8'hFF);
    bus_rd(3'd5, 8'h00, "R8 all cleared");

    // R10 acknowledge clears capture flag
    trig(1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000);
    trig(1'b1, 1'b1, 16'h0000, 16'h0000, 16'h0042);
    bus_rd(3'd5, 8'h20, "R10 flag before ack");
    ack = 1'b1; tick(); ack = 1'b0;
    bus_rd(3'd5, 8'h00, "R10 flag after ack");

    // R11 interrupt gating
    bus_wr(3'd4, 8'hFF);
    bus_rd(3'd4, 8'h3C, "R11 mask unused bits");
    bus_wr(3'd4, 8'h24);
    gie = 1'b1;
    ovf = 1'b1; tick(); ovf = 1'b0;
    tick();
    check("R11 ovf irq", {28'd0, irq}, 32'h1);
    gie = 1'b0; tick(); tick();
    check("R11 gie off", {28'd0, irq}, 32'h0);
    gie = 1'b1;
    ma = 1'b1; tick(); ma = 1'b0;
    tick();
    check("R11 masked source", {28'd0, irq}, 32'h1);
    bus_wr(3'd5, 8'h3C);
    tick();
    check("R11 cleared", {28'd0, irq}, 32'h0);

    tick(); tick(); tick();
    check("monitor drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule